// File: doc/BRIEF.md
# DAC Output Clamp and Deglitch Sequencer

This block governs the switches around the output buffer of a voltage-output DAC. It drives two gate enables. One connects the buffer to the output pin through the series path. The other ties the pin to ground through the clamp. It also drives a hold request to the output track-and-hold buffer. The pin stays tied to ground until two things are true: the supply monitor reports good rails, and a fresh code word has been loaded. Whenever the series path is connected, the clamp is released, so the amplifier never drives into a grounded pin.

An active-low external reset, for example from a battery supervisor, sends the output back to the clamped state at any time. The output then stays clamped until another word is loaded while that reset is high. Each falling (leading) edge of the active-low load strobe starts a timed hold window. During the window the buffer keeps its previous voltage while the conversion core settles. A load strobe that is tied low never starts a window. The supply-good flag is also passed straight through to a reset output for the rest of the system.

Top module: `dac_guard_seq`

## Requirements
- R1: After the system reset `rst_n` is released, `clamp_en_o` is 1, `series_en_o` is 0 and `hold_o` is 0.
- R2: `series_en_o` and `clamp_en_o` are never 1 together, and exactly one of them is 1 in every cycle.
- R3: If `supply_ok_i` is 0 at a rising clock edge, the outputs are clamped after that edge (`clamp_en_o`=1, `series_en_o`=0). They stay clamped until a later release as in R4.
- R4: The output is released (`series_en_o`=1, `clamp_en_o`=0) only after an edge at which all of these hold: `word_loaded_i`=1, `supply_ok_i`=1 and the synchronized external reset is high. Without such an edge, the released state never starts.
- R5: `ext_rst_n_i` passes through a two-flop synchronizer. A low level on it that is sampled at edge k clamps the output after edge k+2. After the pin returns high, the output stays clamped until a new load as in R4.
- R6: If the synchronized external reset is low at the same edge as a `word_loaded_i` pulse, the reset wins and the output stays clamped.
- R7: `ldac_n_i` passes through a two-flop synchronizer. A 1-to-0 change on it that is first sampled at edge k raises `hold_o` after edge k+2. `hold_o` then stays 1 for exactly HOLD_CYC cycles, where HOLD_CYC = CLK_HZ/1000*HOLD_NS/1000000.
- R8: A new falling edge detected while `hold_o` is 1 restarts the window, so `hold_o` stays 1 for a full HOLD_CYC cycles from the new start.
- R9: If `ldac_n_i` is held at 0 from reset onward, `hold_o` never becomes 1.
- R10: `sup_rst_o` always equals `supply_ok_i`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| supply_ok_i | input | 1 | Supply-good flag from the voltage monitor, synchronous to clk |
| ext_rst_n_i | input | 1 | External active-low reset request, asynchronous |
| word_loaded_i | input | 1 | One-cycle pulse: a valid word was written to the DAC register |
| ldac_n_i | input | 1 | Active-low load strobe, asynchronous |
| series_en_o | output | 1 | 1 connects the buffer to the output pin |
| clamp_en_o | output | 1 | 1 ties the output pin to ground |
| hold_o | output | 1 | 1 puts the output buffer in hold |
| sup_rst_o | output | 1 | Supply-good status passed to the rest of the system |

## Verification
The bench builds the block with CLK_HZ = 50 MHz and HOLD_NS = 200, which gives a hold window of 10 cycles instead of the default 250. With the short window, a complete window fits inside each phase. It also lets the bench retrigger the window in its middle and check how the window ends, all within a few hundred cycles. The two-stage synchronizers keep their default depth, so the bench's reference model can use the fixed latencies in R5 and R7. Every cycle, the bench compares all four outputs against this model.

// File: rtl/dac_guard_seq.sv
module dac_guard_seq #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int HOLD_NS     = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic ext_rst_n_i,
  input  logic word_loaded_i,
  input  logic ldac_n_i,
  output logic series_en_o,
  output logic clamp_en_o,
  output logic hold_o,
  output logic sup_rst_o
);

  localparam int HOLD_RAW = (CLK_HZ / 1000) * HOLD_NS / 1_000_000;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int CNT_W    = $clog2(HOLD_CYC + 1);

  logic [SYNC_STAGES-1:0] ext_sync;
  logic [SYNC_STAGES-1:0] ldac_sync;
  logic                   ldac_prev;
  logic [CNT_W-1:0]       hold_cnt;

  wire ext_ok    = ext_sync[SYNC_STAGES-1];
  wire ldac_s    = ldac_sync[SYNC_STAGES-1];
  wire ldac_fall = ldac_prev & ~ldac_s;
  wire force_clamp = ~supply_ok_i | ~ext_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync  <= '0;
      ldac_sync <= '0;
      ldac_prev <= 1'b0;
    end else begin
      ext_sync  <= {ext_sync[SYNC_STAGES-2:0], ext_rst_n_i};
      ldac_sync <= {ldac_sync[SYNC_STAGES-2:0], ldac_n_i};
      ldac_prev <= ldac_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      series_en_o <= 1'b0;
      clamp_en_o  <= 1'b1;
    end else if (force_clamp) begin
      series_en_o <= 1'b0;
      clamp_en_o  <= 1'b1;
    end else if (word_loaded_i) begin
      series_en_o <= 1'b1;
      clamp_en_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (ldac_fall)
      hold_cnt <= CNT_W'(HOLD_CYC);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  assign hold_o    = (hold_cnt != '0);
  assign sup_rst_o = supply_ok_i;

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    series_en_o != clamp_en_o);

  assert_supply_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (clamp_en_o && !series_en_o));

  assert_release_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(series_en_o) |-> $past(word_loaded_i && supply_ok_i && ext_ok));

  assert_ext_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ok |=> clamp_en_o);

  assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_loaded_i && !ext_ok) |=> !series_en_o);

  assert_hold_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_fall |=> hold_o);

  assert_hold_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(ldac_fall));

  always_comb assert_passthru_R10: assert (sup_rst_o == supply_ok_i);

endmodule

// File: tb/dac_guard_seq_bench.sv
module dac_guard_seq_bench;
  localparam int HOLD = 10;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, ext_rst_n = 1, word_loaded = 0, ldac_n = 0;
  logic series_en, clamp_en, hold, sup_rst;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  dac_guard_seq #(.CLK_HZ(50_000_000), .HOLD_NS(200)) u_dac_guard_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .ext_rst_n_i(ext_rst_n),
    .word_loaded_i(word_loaded), .ldac_n_i(ldac_n),
    .series_en_o(series_en), .clamp_en_o(clamp_en), .hold_o(hold), .sup_rst_o(sup_rst));

  always #10 clk = ~clk;

  bit ext_q[$];
  bit ldac_q[$];
  bit m_live = 0;
  int m_left = 0;

  always @(posedge clk) begin
    bit ldac_old_prev, ldac_old_cur, ext_cur;
    if (!rst_n) begin
      ext_q = '{0, 0};
      ldac_q = '{0, 0, 0};
      m_live = 0;
      m_left = 0;
    end else begin
      ext_cur = ext_q[1];
      ldac_old_prev = ldac_q[0];
      ldac_old_cur = ldac_q[1];
      if (!supply_ok || !ext_cur) m_live = 0;
      else if (word_loaded) m_live = 1;
      if (ldac_old_prev && !ldac_old_cur) m_left = HOLD;
      else if (m_left > 0) m_left--;
      void'(ext_q.pop_back());
      ext_q.push_front(ext_rst_n);
      void'(ldac_q.pop_front());
      ldac_q.push_back(ldac_n);
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(cur_req, "series_en", series_en, m_live);
      check(cur_req, "clamp_en", clamp_en, !m_live);
      check("R2", "exclusive", series_en & clamp_en, 1'b0);
      check(cur_req, "hold", hold, m_left > 0);
      check("R10", "sup_rst", sup_rst, supply_ok);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load();
    @(negedge clk) word_loaded = 1;
    @(negedge clk) word_loaded = 0;
  endtask

  task automatic ldac_pulse();
    @(negedge clk) ldac_n = 1;
    cyc(3);
    ldac_n = 0;
  endtask

  initial begin
    #5000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk) rst_n = 1;
    cur_req = "R1";
    check("R1", "reset clamp", clamp_en, 1'b1);
    check("R1", "reset series", series_en, 1'b0);
    check("R1", "reset hold", hold, 1'b0);
    cyc(5);

    cur_req = "R9";
    cyc(40);
    check("R9", "ldac low no hold", hold, 1'b0);

    cur_req = "R4";
    load();
    cyc(3);
    check("R4", "no release without supply", series_en, 1'b0);
    @(negedge clk) supply_ok = 1;
    cyc(4);
    check("R4", "no release without load", series_en, 1'b0);
    load();
    cyc(1);
    check("R4", "released", series_en, 1'b1);

    cur_req = "R3";
    @(negedge clk) supply_ok = 0;
    cyc(1);
    check("R3", "supply drop clamps", clamp_en, 1'b1);
    @(negedge clk) supply_ok = 1;
    cyc(5);
    check("R3", "stays clamped", clamp_en, 1'b1);
    load();
    cyc(1);
    check("R3", "reload releases", series_en, 1'b1);

    cur_req = "R5";
    @(negedge clk) ext_rst_n = 0;
    cyc(4);
    check("R5", "ext reset clamps", clamp_en, 1'b1);
    @(negedge clk) ext_rst_n = 1;
    cyc(6);
    check("R5", "stays clamped after ext", clamp_en, 1'b1);
    load();
    cyc(1);
    check("R5", "reload after ext", series_en, 1'b1);

    cur_req = "R6";
    @(negedge clk) ext_rst_n = 0;
    cyc(2);
    word_loaded = 1;
    cyc(3);
    word_loaded = 0;
    check("R6", "reset beats load", series_en, 1'b0);
    @(negedge clk) ext_rst_n = 1;
    cyc(5);
    load();

    cur_req = "R7";
    ldac_pulse();
    cyc(HOLD + 6);
    check("R7", "hold ended", hold, 1'b0);

    cur_req = "R8";
    ldac_pulse();
    cyc(5);
    ldac_pulse();
    cyc(HOLD + 6);

    cur_req = "R7";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) ldac_n = 1;
      cyc(i + 2);
      ldac_n = 0;
      cyc(HOLD + 4);
    end

    cur_req = "R10";
    @(negedge clk) supply_ok = 0;
    #3 check("R10", "passthru low", sup_rst, 1'b0);
    cyc(3);
    supply_ok = 1;
    #3 check("R10", "passthru high", sup_rst, 1'b1);
    cyc(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule